// File: doc/BRIEF.md
# Octave-Folded Twiddle Coefficient Generator

This block supplies the complex coefficient W = e^(-j·2π·e/M) for one twiddle multiplier in a pipelined FFT with resolution M = 2^K. The exponent e is K bits wide, so it is always read modulo M. The block drives separate signed real and imaginary words. Each cycle that carries a valid exponent returns a valid coefficient two clock cycles later. The pipeline accepts a new exponent every cycle.

A full coefficient table would hold M complex words. This block stores cosine and sine only for angles from 0 up to and including π/4, which is M/8+1 entries. The table is computed while the design elaborates. The three most significant exponent bits select one of eight octants. In odd octants the offset within the octant is reflected as M/8 minus the low bits, and this is why the entry at π/4 is kept. The other seven octants are rebuilt from the stored octant by swapping the real and imaginary parts and changing their signs. Values are in Q1.14 format, so +1.0 is 16384. That value still fits in a 16-bit word after it is negated.

Top module: `twiddle_oct_rom`

## Requirements
- R1: For every e in [0, M), the output real part equals round(cos(2πe/M)·16384) and the imaginary part equals round(−sin(2πe/M)·16384). Rounding is to the nearest integer, with halves rounded away from zero. The results match a full M-entry table bit for bit.
- R2: The four axis exponents give exact unit values: e=0 gives (16384, 0), e=M/4 gives (0, −16384), e=M/2 gives (−16384, 0) and e=3M/4 gives (0, 16384).
- R3: At octant boundaries e = M/8, 3M/8, 5M/8 and 7M/8, both parts have magnitude 11585. e=M/8 gives (11585, −11585) and e=7M/8 gives (11585, 11585). Both boundary neighbours are correct: e=1 gives (16305, −1606) at M=64, and e=M−1 is its conjugate.
- R4: While the output is valid, neither part has a magnitude above 16384.
- R5: The output valid equals the input valid delayed by exactly two clock cycles, and the coefficient belongs to the exponent presented on that earlier cycle.
- R6: While no valid exponent is accepted, the output valid is low and the output words hold their last values, whatever the exponent input does.
- R7: While reset is asserted (rst_ni low, asynchronous), the output valid and both output words are zero.
- R8: A new exponent can be presented every cycle. The coefficients come out in the same order, one per cycle, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exp_vld_i | input | 1 | Exponent valid strobe |
| exp_i | input | K = log2(M) | Twiddle exponent e |
| tw_vld_o | output | 1 | Coefficient valid, two cycles after exp_vld_i |
| tw_re_o | output | 16 | Real part, Q1.14 two's complement |
| tw_im_o | output | 16 | Imaginary part, Q1.14 two's complement |

## Verification
The bench builds two copies of the block. One uses M=64, where each octant spans only eight exponents, so every reflection, swap and sign case is reached within a short stream. The other uses M=1024, where the stored octant has 129 entries and the reflected index covers a wide range. Both copies are swept over every exponent and compared against a full-circle reference that the bench computes itself. The bench then uses the M=64 copy for directed checks on the axis values, octant edges, hold behaviour and reset.

// File: rtl/twid_pkg.sv
package twid_pkg;
  localparam int unsigned TW_W    = 16;
  localparam int unsigned TW_FRAC = 14;
  localparam real         TW_PI   = 3.14159265358979323846;

  typedef logic signed [TW_W-1:0] tw_word_t;

  // Round to nearest integer, halves away from zero.
  function automatic int round_away(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(-x + 0.5);
  endfunction
endpackage

// File: rtl/twid_fold.sv
module twid_fold #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] exp_i,
  output logic [2:0]   oct_o,
  output logic [K-3:0] idx_o
);
  localparam int unsigned LW = K - 3;
  localparam logic [K-3:0] Q = (K-2)'(1) << LW;

  logic [LW-1:0] low;

  always_comb begin
    oct_o = exp_i[K-1:K-3];
    low   = exp_i[LW-1:0];
    // odd octants run backwards through the stored octant
    if (oct_o[0]) idx_o = Q - {1'b0, low};
    else          idx_o = {1'b0, low};
  end
endmodule

// File: rtl/twid_octant_rom.sv
module twid_octant_rom
  import twid_pkg::*;
#(
  parameter int unsigned K = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [K-3:0] idx_i,
  output tw_word_t     cos_o,
  output tw_word_t     sin_o
);
  localparam int unsigned M = 1 << K;
  localparam int unsigned Q = M / 8;
  localparam real SCALE = real'(1 << TW_FRAC);

  tw_word_t cos_tab [Q+1];
  tw_word_t sin_tab [Q+1];
  tw_word_t cos_d, sin_d;

  for (genvar i = 0; i <= Q; i++) begin : g_tab
    localparam real ANG = 2.0 * TW_PI * real'(i) / real'(M);
    assign cos_tab[i] = TW_W'(round_away($cos(ANG) * SCALE));
    assign sin_tab[i] = TW_W'(round_away($sin(ANG) * SCALE));
  end

  always_comb begin
    cos_d = cos_o;
    sin_d = sin_o;
    if (en_i) begin
      cos_d = cos_tab[idx_i];
      sin_d = sin_tab[idx_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      cos_o <= cos_d;
      sin_o <= sin_d;
    end
  end
endmodule

// File: rtl/twid_unfold.sv
module twid_unfold
  import twid_pkg::*;
(
  input  logic [2:0] oct_i,
  input  tw_word_t   cos_i,
  input  tw_word_t   sin_i,
  output tw_word_t   re_o,
  output tw_word_t   im_o
);
  logic     swap, neg_re, neg_im;
  tw_word_t pa, pb;

  always_comb begin
    swap   = oct_i[0] ^ oct_i[1];   // octants 1,2,5,6
    neg_re = oct_i[2] ^ oct_i[1];   // octants 2..5 (left half plane)
    neg_im = ~oct_i[2];             // octants 0..3 (upper half, -sin)
    pa     = swap ? sin_i : cos_i;
    pb     = swap ? cos_i : sin_i;
    re_o   = neg_re ? -pa : pa;
    im_o   = neg_im ? -pb : pb;
  end
endmodule

// File: rtl/twiddle_oct_rom.sv
module twiddle_oct_rom
  import twid_pkg::*;
#(
  parameter int unsigned M = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 exp_vld_i,
  input  logic [$clog2(M)-1:0] exp_i,
  output logic                 tw_vld_o,
  output logic [TW_W-1:0]      tw_re_o,
  output logic [TW_W-1:0]      tw_im_o
);
  localparam int unsigned K = $clog2(M);
  localparam int ONE = 1 << TW_FRAC;

  logic [2:0]   oct_d, oct_q;
  logic [K-3:0] idx;
  logic         vld_q;
  tw_word_t     cos_q, sin_q, re_d, im_d, re_q, im_q;
  logic [2:0]   oct_nx;
  logic         vld_nx, out_vld_nx;
  tw_word_t     re_nx, im_nx;

  twid_fold #(.K(K)) fold_i (.exp_i(exp_i), .oct_o(oct_d), .idx_o(idx));

  twid_octant_rom #(.K(K)) rom_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(exp_vld_i),
    .idx_i(idx), .cos_o(cos_q), .sin_o(sin_q)
  );

  twid_unfold unfold_i (
    .oct_i(oct_q), .cos_i(cos_q), .sin_i(sin_q), .re_o(re_d), .im_o(im_d)
  );

  // next-state
  always_comb begin
    vld_nx     = exp_vld_i;
    oct_nx     = exp_vld_i ? oct_d : oct_q;
    out_vld_nx = vld_q;
    re_nx      = vld_q ? re_d : re_q;
    im_nx      = vld_q ? im_d : im_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      oct_q    <= '0;
      tw_vld_o <= 1'b0;
      re_q     <= '0;
      im_q     <= '0;
    end else begin
      vld_q    <= vld_nx;
      oct_q    <= oct_nx;
      tw_vld_o <= out_vld_nx;
      re_q     <= re_nx;
      im_q     <= im_nx;
    end
  end

  assign tw_re_o = re_q;
  assign tw_im_o = im_q;

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_vld_o == $past(exp_vld_i, 2));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(exp_vld_i, 2) |-> ($stable(tw_re_o) && $stable(tw_im_o)));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_vld_o |-> ($signed(tw_re_o) <= ONE && $signed(tw_re_o) >= -ONE &&
                  $signed(tw_im_o) <= ONE && $signed(tw_im_o) >= -ONE));

  a_r2_unit_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(exp_vld_i, 2) && $past(exp_i, 2) == '0) |->
      ($signed(tw_re_o) == ONE && tw_im_o == '0));
endmodule

// File: tb/twiddle_oct_rom_tb_top.sv
module twiddle_oct_rom_tb_top;
  localparam int MS = 64;
  localparam int MB = 1024;
  localparam real PI_R = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [9:0] ex = '0;
  logic s_vld, b_vld;
  logic [15:0] s_re, s_im, b_re, b_im;
  int total = 0, bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  twiddle_oct_rom #(.M(MS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exp_vld_i(vld), .exp_i(ex[5:0]),
    .tw_vld_o(s_vld), .tw_re_o(s_re), .tw_im_o(s_im));

  twiddle_oct_rom #(.M(MB)) dut_big_i (
    .clk_i(clk), .rst_ni(rst_n), .exp_vld_i(vld), .exp_i(ex),
    .tw_vld_o(b_vld), .tw_re_o(b_re), .tw_im_o(b_im));

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction
  function automatic int ref_re(input int m, input int e);
    return rnd($cos(2.0 * PI_R * e / m) * 16384.0);
  endfunction
  function automatic int ref_im(input int m, input int e);
    return rnd(-$sin(2.0 * PI_R * e / m) * 16384.0);
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // {exponent, re, im} at M=64
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{0, 16384, 0}, '{8, 11585, -11585}, '{16, 0, -16384},
    '{24, -11585, -11585}, '{32, -16384, 0}, '{40, -11585, 11585},
    '{48, 0, 16384}, '{56, 11585, 11585}, '{1, 16305, -1606},
    '{63, 16305, 1606}};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int last_re, last_im;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 vld", s_vld, 0); chk("R7 re", s_re, 0); chk("R7 im", s_im, 0);
    rst_n = 1'b1;

    // vector table: R2, R3, R5 (single strobe, two-cycle latency)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ex = 10'(VEC[v][0]); vld = 1'b1;
      @(negedge clk);
      vld = 1'b0; ex = 10'h3ff;
      chk("R5 not yet valid", s_vld, 0);
      @(negedge clk);
      chk("R5 valid", s_vld, 1);
      chk("R2/R3 re", $signed(s_re), VEC[v][1]);
      chk("R2/R3 im", $signed(s_im), VEC[v][2]);
    end

    // R1, R8: back-to-back sweep, both sizes
    for (int t = 0; t < MB + 2; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        chk("R8 big vld", b_vld, 1);
        chk("R1 big re", $signed(b_re), ref_re(MB, t - 2));
        chk("R1 big im", $signed(b_im), ref_im(MB, t - 2));
        chk("R1 small re", $signed(s_re), ref_re(MS, (t - 2) % MS));
        chk("R1 small im", $signed(s_im), ref_im(MS, (t - 2) % MS));
        if ($signed(s_re) > 16384 || $signed(s_re) < -16384)
          chk("R4 magnitude", $signed(s_re), 16384);
      end
      if (t < MB) begin vld = 1'b1; ex = 10'(t); end
      else begin vld = 1'b0; ex = 10'h155; end
    end

    // R6: hold while idle, exponent keeps moving
    last_re = $signed(s_re); last_im = $signed(s_im);
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      ex = 10'(h * 37);
      chk("R6 vld low", s_vld, 0);
      chk("R6 re held", $signed(s_re), last_re);
      chk("R6 im held", $signed(s_im), last_im);
    end

    // R7: asynchronous reset mid-run
    @(negedge clk); ex = 10'd20; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    @(negedge clk);
    chk("R1 pre-reset re", $signed(s_re), ref_re(MS, 20));
    #1 rst_n = 1'b0;
    #1;
    chk("R7 async vld", s_vld, 0); chk("R7 async re", s_re, 0);
    chk("R7 async im", s_im, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", s_vld, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule